// File: doc/BRIEF.md
# Dual-Mode Timer Peripheral with Interrupts

This block is a memory-mapped timer behind a simple single-cycle register bus. The bus has a byte address, a write enable, write data and combinational read data. A configuration word picks how timer A runs when it is next enabled:
- **Down-counter mode** (configuration 0): the timer counts clock cycles from a 32-bit load value and raises an expiry flag each time the count ends. It runs either once or repeatedly.
- **Seconds-counter mode** (configuration 1): a 32-bit count advances on an external once-per-second strobe and wraps to zero once it passes a 32-bit match value.

The 32-bit load and match values are kept as two 16-bit halves. The upper half can be written through the timer A address only while the configuration is below 4. Otherwise it is written through the timer B address.

Expiry and wrap events set bits in a raw status word. A bus write of ones clears those bits. A mask selects which status bits drive the level interrupt line. When its control bit is set, an expiry also produces a one-cycle trigger pulse.

Timer A is run by a small state machine with four states:
- **IDLE**: stopped.
- **DOWN**: counting down.
- **RTC**: counting seconds strobes.
- **HOLD**: enabled in a configuration that has no counting function.

The transitions are:
- **launch** (IDLE to DOWN, RTC or HOLD): taken on a 0-to-1 change of control bit 0. The target state comes from the configuration word at that moment.
- **halt** (any running state to IDLE): taken on a 1-to-0 change of control bit 0.
- **expire-stop** (DOWN to IDLE): taken on expiry in one-shot mode.
- **expire-reload** (DOWN to DOWN): taken on expiry in periodic mode.

Prescaler, prescale-match and timer B mode words are plain storage.

Top module: `dmt_timer`

## Requirements
- R1: After reset, every register read returns 0, and both `irq` and `trig` are low.
- R2: The words at the following byte offsets read back exactly what was last written:
  - configuration 0x00
  - mode A 0x04
  - mode B 0x08
  - control 0x0C
  - prescale A 0x38
  - prescale B 0x3C
  - prescale-match A 0x40
  - prescale-match B 0x44
  Reads of the clear word 0x24 and of unmapped offsets (such as 0x10, 0x14, 0x4C, 0x50) return 0.
- R3: The load A write rule (offset 0x28) is:
  - bits 15:0 are always stored as the low half;
  - bits 31:16 are stored as the high half only while the configuration is below 4.
  The load A read rule is:
  - while the configuration is below 4, it returns {high, low};
  - otherwise it returns {16'h0, low}.
  Load B (offset 0x2C) writes bits 15:0 into the high half and reads it back in bits 15:0. Match A (0x30) and match B (0x34) follow the same rules.
- R4: The down-counter launches when control bit 0 goes from 0 to 1 while the configuration is 0. It loads the load value L at that clock edge. Raw status bit 0 is set max(L,1) clock edges after the launch edge.
- R5: When mode A bit 0 is 0, the down-counter reloads at every expiry. Expiries then repeat every max(L,1) clocks.
- R6: When mode A bit 0 is 1, the first expiry clears control bit 0 and no later expiry occurs. Control bit 5 keeps its value.
- R7: On each expiry, `trig` is high for the one cycle after the expiry edge when control bit 5 is 1. When control bit 5 is 0, `trig` stays low.
- R8: A 1-to-0 change of control bit 0 stops the counter. No expiry or trigger follows.
- R9: In seconds-counter mode each strobe sets the count to count+1. If that value is greater than the match value, the count becomes 0 instead. Raw status bit 3 is set whenever the updated count is 0.
- R10: Counter A (offset 0x48) reads the seconds count while the configuration is 1, and reads 0 otherwise.
- R11: Mask writes (offset 0x18) keep only the bits in 0x77. Masked status (offset 0x20) reads raw AND mask. `irq` is high exactly when that AND is nonzero.
- R12: A write to the clear word (offset 0x24) clears every raw status bit written as 1 and leaves the other bits unchanged.
- R13: Writes to the configuration or mode A change nothing in a running counter until the next launch. While the state is not RTC, strobes do not change the seconds count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| sec_tick | input | 1 | One-cycle once-per-second strobe |
| irq | output | 1 | Level interrupt: raw status AND mask is nonzero |
| trig | output | 1 | One-cycle pulse on expiry when enabled |

## Verification
The bench builds the block with its default parameters, DATA_W = 32 and ADDR_W = 8. Every register offset is therefore decodable, and both write rules for the split load and match halves can be reached.

The load value is swept from 0 to 6 in one-shot and in periodic mode. This covers the zero-load boundary, where the period is one clock, and several whole periods inside a short window. The expected count of trigger pulses is computed as the window length divided by the period.

The match value is swept from 0 to 3 with a run of strobes. Each wrap and each zero flag is compared against an arithmetic model of the count. This includes counts left above a newly lowered match value.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DOWN = 2'd1,
        ST_RTC  = 2'd2,
        ST_HOLD = 2'd3
    } run_state_e;

    // byte offsets decoded by the register file
    localparam int OFS_CFG    = 'h00;
    localparam int OFS_MODE_A = 'h04;
    localparam int OFS_MODE_B = 'h08;
    localparam int OFS_CTL    = 'h0C;
    localparam int OFS_MASK   = 'h18;
    localparam int OFS_RAW    = 'h1C;
    localparam int OFS_MSK_ST = 'h20;
    localparam int OFS_CLR    = 'h24;
    localparam int OFS_LOAD_A = 'h28;
    localparam int OFS_LOAD_B = 'h2C;
    localparam int OFS_MTCH_A = 'h30;
    localparam int OFS_MTCH_B = 'h34;
    localparam int OFS_PSC_A  = 'h38;
    localparam int OFS_PSC_B  = 'h3C;
    localparam int OFS_PMT_A  = 'h40;
    localparam int OFS_PMT_B  = 'h44;
    localparam int OFS_CNT_A  = 'h48;

    localparam int CFG_DOWN   = 0;
    localparam int CFG_RTC    = 1;
    localparam int CFG_SPLIT  = 4;

    localparam int CTL_EN_A   = 0;
    localparam int CTL_TRG_EN = 5;

    localparam int RAW_EXPIRE = 0;
    localparam int RAW_WRAP   = 3;

    localparam int MASK_KEEP  = 'h77;

endpackage

// File: rtl/dmt_regs.sv
module dmt_regs
    import dmt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              en_clr,
    input  logic [DATA_W-1:0] rstat_q,
    input  logic [DATA_W-1:0] masked_st,
    input  logic [DATA_W-1:0] rtc_q,
    output logic [DATA_W-1:0] cfg_q,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] imask_q,
    output logic              oneshot_sel,
    output logic [DATA_W-1:0] load_w,
    output logic [DATA_W-1:0] match_w,
    output logic              start_a,
    output logic              stop_a,
    output logic              clr_wr
);
    localparam int HALF_W = DATA_W / 2;
    localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_MODE_A = ADDR_W'(OFS_MODE_A);
    localparam logic [ADDR_W-1:0] A_MODE_B = ADDR_W'(OFS_MODE_B);
    localparam logic [ADDR_W-1:0] A_CTL    = ADDR_W'(OFS_CTL);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_MSK_ST = ADDR_W'(OFS_MSK_ST);
    localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_LOAD_A = ADDR_W'(OFS_LOAD_A);
    localparam logic [ADDR_W-1:0] A_LOAD_B = ADDR_W'(OFS_LOAD_B);
    localparam logic [ADDR_W-1:0] A_MTCH_A = ADDR_W'(OFS_MTCH_A);
    localparam logic [ADDR_W-1:0] A_MTCH_B = ADDR_W'(OFS_MTCH_B);
    localparam logic [ADDR_W-1:0] A_PSC_A  = ADDR_W'(OFS_PSC_A);
    localparam logic [ADDR_W-1:0] A_PSC_B  = ADDR_W'(OFS_PSC_B);
    localparam logic [ADDR_W-1:0] A_PMT_A  = ADDR_W'(OFS_PMT_A);
    localparam logic [ADDR_W-1:0] A_PMT_B  = ADDR_W'(OFS_PMT_B);
    localparam logic [ADDR_W-1:0] A_CNT_A  = ADDR_W'(OFS_CNT_A);
    localparam logic [DATA_W-1:0] KEEP_BITS = DATA_W'(MASK_KEEP);

    logic [DATA_W-1:0] mode_a_q, mode_b_q;
    logic [DATA_W-1:0] psc_a_q, psc_b_q, pmt_a_q, pmt_b_q;
    logic [HALF_W-1:0] ld_lo_q, ld_hi_q, mt_lo_q, mt_hi_q;
    logic              combined;
    logic              wr_ctl;

    assign combined    = cfg_q < DATA_W'(CFG_SPLIT);
    assign wr_ctl      = bus_we && (bus_addr == A_CTL);
    assign start_a     = wr_ctl &&  bus_wdata[CTL_EN_A] && !ctrl_q[CTL_EN_A];
    assign stop_a      = wr_ctl && !bus_wdata[CTL_EN_A] &&  ctrl_q[CTL_EN_A];
    assign clr_wr      = bus_we && (bus_addr == A_CLR);
    assign oneshot_sel = mode_a_q[0];
    assign load_w      = {ld_hi_q, ld_lo_q};
    assign match_w     = {mt_hi_q, mt_lo_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            mode_a_q <= '0;
            mode_b_q <= '0;
            ctrl_q   <= '0;
            imask_q  <= '0;
            psc_a_q  <= '0;
            psc_b_q  <= '0;
            pmt_a_q  <= '0;
            pmt_b_q  <= '0;
            ld_lo_q  <= '0;
            ld_hi_q  <= '0;
            mt_lo_q  <= '0;
            mt_hi_q  <= '0;
        end else begin
            // one-shot expiry drops the enable; a bus write below wins
            if (en_clr) begin
                ctrl_q[CTL_EN_A] <= 1'b0;
            end
            if (bus_we) begin
                case (bus_addr)
                    A_CFG:    cfg_q    <= bus_wdata;
                    A_MODE_A: mode_a_q <= bus_wdata;
                    A_MODE_B: mode_b_q <= bus_wdata;
                    A_CTL:    ctrl_q   <= bus_wdata;
                    A_MASK:   imask_q  <= bus_wdata & KEEP_BITS;
                    A_PSC_A:  psc_a_q  <= bus_wdata;
                    A_PSC_B:  psc_b_q  <= bus_wdata;
                    A_PMT_A:  pmt_a_q  <= bus_wdata;
                    A_PMT_B:  pmt_b_q  <= bus_wdata;
                    A_LOAD_A: begin
                        ld_lo_q <= bus_wdata[HALF_W-1:0];
                        if (combined) ld_hi_q <= bus_wdata[DATA_W-1:HALF_W];
                    end
                    A_LOAD_B: ld_hi_q <= bus_wdata[HALF_W-1:0];
                    A_MTCH_A: begin
                        mt_lo_q <= bus_wdata[HALF_W-1:0];
                        if (combined) mt_hi_q <= bus_wdata[DATA_W-1:HALF_W];
                    end
                    A_MTCH_B: mt_hi_q <= bus_wdata[HALF_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CFG:    bus_rdata = cfg_q;
            A_MODE_A: bus_rdata = mode_a_q;
            A_MODE_B: bus_rdata = mode_b_q;
            A_CTL:    bus_rdata = ctrl_q;
            A_MASK:   bus_rdata = imask_q;
            A_RAW:    bus_rdata = rstat_q;
            A_MSK_ST: bus_rdata = masked_st;
            A_LOAD_A: bus_rdata = combined ? {ld_hi_q, ld_lo_q} : {{HALF_W{1'b0}}, ld_lo_q};
            A_LOAD_B: bus_rdata = {{HALF_W{1'b0}}, ld_hi_q};
            A_MTCH_A: bus_rdata = combined ? {mt_hi_q, mt_lo_q} : {{HALF_W{1'b0}}, mt_lo_q};
            A_MTCH_B: bus_rdata = {{HALF_W{1'b0}}, mt_hi_q};
            A_PSC_A:  bus_rdata = psc_a_q;
            A_PSC_B:  bus_rdata = psc_b_q;
            A_PMT_A:  bus_rdata = pmt_a_q;
            A_PMT_B:  bus_rdata = pmt_b_q;
            A_CNT_A:  bus_rdata = (cfg_q == DATA_W'(CFG_RTC)) ? rtc_q : '0;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dmt_status.sv
module dmt_status
    import dmt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_expire,
    input  logic              set_wrap,
    input  logic              clr_wr,
    input  logic [DATA_W-1:0] clr_val,
    input  logic [DATA_W-1:0] imask_q,
    output logic [DATA_W-1:0] rstat_q,
    output logic [DATA_W-1:0] masked_st,
    output logic              irq
);
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] clr_vec;

    always_comb begin
        set_vec             = '0;
        set_vec[RAW_EXPIRE] = set_expire;
        set_vec[RAW_WRAP]   = set_wrap;
        clr_vec             = clr_wr ? clr_val : '0;
    end

    // a new event in the same cycle as a clear survives it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rstat_q <= '0;
        end else begin
            rstat_q <= (rstat_q & ~clr_vec) | set_vec;
        end
    end

    assign masked_st = rstat_q & imask_q;
    assign irq       = |masked_st;

endmodule

// File: rtl/dmt_rtc.sv
module dmt_rtc #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rtc_adv,
    input  logic [DATA_W-1:0] match_w,
    output logic [DATA_W-1:0] rtc_q,
    output logic              rtc_wrap
);
    logic [DATA_W-1:0] bumped;
    logic [DATA_W-1:0] rtc_d;

    always_comb begin
        bumped = rtc_q + DATA_W'(1);
        rtc_d  = (bumped > match_w) ? '0 : bumped;
    end

    assign rtc_wrap = rtc_adv && (rtc_d == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rtc_q <= '0;
        end else if (rtc_adv) begin
            rtc_q <= rtc_d;
        end
    end

endmodule

// File: rtl/dmt_fsm.sv
module dmt_fsm
    import dmt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_a,
    input  logic              stop_a,
    input  logic [DATA_W-1:0] cfg_q,
    input  logic              oneshot_sel,
    input  logic              trig_en,
    input  logic [DATA_W-1:0] load_w,
    input  logic              sec_tick,
    output run_state_e        state_q,
    output logic              expire,
    output logic              en_clr,
    output logic              rtc_adv,
    output logic              trig
);
    run_state_e        state_d;
    run_state_e        launch_state;
    logic [DATA_W-1:0] cnt_q;
    logic              oneshot_q;
    logic              cnt_done;

    assign cnt_done = cnt_q <= DATA_W'(1);

    always_comb begin
        if (cfg_q == DATA_W'(CFG_DOWN)) begin
            launch_state = ST_DOWN;
        end else if (cfg_q == DATA_W'(CFG_RTC)) begin
            launch_state = ST_RTC;
        end else begin
            launch_state = ST_HOLD;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: launch, halt, expire-stop, expire-reload
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_a) state_d = launch_state;
            end
            ST_DOWN: begin
                if (stop_a) begin
                    state_d = ST_IDLE;
                end else if (cnt_done && oneshot_q) begin
                    state_d = ST_IDLE;
                end
            end
            ST_RTC, ST_HOLD: begin
                if (stop_a) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        expire  = (state_q == ST_DOWN) && !stop_a && cnt_done;
        en_clr  = expire && oneshot_q;
        rtc_adv = (state_q == ST_RTC) && !stop_a && sec_tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            oneshot_q <= 1'b0;
            trig      <= 1'b0;
        end else begin
            trig <= expire && trig_en;
            if ((state_q == ST_IDLE) && start_a) begin
                cnt_q     <= load_w;
                oneshot_q <= oneshot_sel;
            end else if (expire) begin
                cnt_q <= load_w;
            end else if (state_q == ST_DOWN) begin
                cnt_q <= cnt_q - DATA_W'(1);
            end
        end
    end

endmodule

// File: rtl/dmt_timer.sv
module dmt_timer
    import dmt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sec_tick,
    output logic              irq,
    output logic              trig
);
    run_state_e        state_q;
    logic [DATA_W-1:0] cfg_q, ctrl_q, imask_q, load_w, match_w;
    logic [DATA_W-1:0] rstat_q, masked_st, rtc_q;
    logic              oneshot_sel, start_a, stop_a, clr_wr;
    logic              expire, en_clr, rtc_adv, rtc_wrap;

    dmt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .en_clr(en_clr), .rstat_q(rstat_q), .masked_st(masked_st), .rtc_q(rtc_q),
        .cfg_q(cfg_q), .ctrl_q(ctrl_q), .imask_q(imask_q),
        .oneshot_sel(oneshot_sel), .load_w(load_w), .match_w(match_w),
        .start_a(start_a), .stop_a(stop_a), .clr_wr(clr_wr)
    );

    dmt_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_a(start_a), .stop_a(stop_a), .cfg_q(cfg_q),
        .oneshot_sel(oneshot_sel), .trig_en(ctrl_q[CTL_TRG_EN]),
        .load_w(load_w), .sec_tick(sec_tick),
        .state_q(state_q), .expire(expire), .en_clr(en_clr),
        .rtc_adv(rtc_adv), .trig(trig)
    );

    dmt_rtc #(.DATA_W(DATA_W)) u_rtc (
        .clk(clk), .rst_n(rst_n),
        .rtc_adv(rtc_adv), .match_w(match_w),
        .rtc_q(rtc_q), .rtc_wrap(rtc_wrap)
    );

    dmt_status #(.DATA_W(DATA_W)) u_status (
        .clk(clk), .rst_n(rst_n),
        .set_expire(expire), .set_wrap(rtc_wrap),
        .clr_wr(clr_wr), .clr_val(bus_wdata), .imask_q(imask_q),
        .rstat_q(rstat_q), .masked_st(masked_st), .irq(irq)
    );

endmodule

// File: rtl/dmt_timer_chk.sv
module dmt_timer_chk
    import dmt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              sec_tick,
    input logic              irq,
    input logic              trig,
    input run_state_e        state_q,
    input logic [DATA_W-1:0] rstat_q,
    input logic [DATA_W-1:0] ctrl_q,
    input logic [DATA_W-1:0] rtc_q,
    input logic [DATA_W-1:0] match_w,
    input logic              expire,
    input logic              rtc_wrap
);
    logic ctl_wr, clr_all;
    assign ctl_wr  = bus_we && (bus_addr == ADDR_W'(OFS_CTL));
    assign clr_all = bus_we && (bus_addr == ADDR_W'(OFS_CLR)) && (bus_wdata == '1);

    // R12
    clr_all_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && !expire && !rtc_wrap) |=> !irq);

    // R7
    trig_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> rstat_q[RAW_EXPIRE]);

    // R6
    expiry_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DOWN) && expire && !ctl_wr)
            |=> (ctrl_q[CTL_EN_A] == (state_q == ST_DOWN)));

    // R9
    rtc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RTC) && sec_tick && !bus_we) |=> (rtc_q <= match_w));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !trig);

    // R13
    rtc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RTC) |=> $stable(rtc_q));

endmodule

bind dmt_timer dmt_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .sec_tick(sec_tick), .irq(irq), .trig(trig),
    .state_q(state_q), .rstat_q(rstat_q), .ctrl_q(ctrl_q), .rtc_q(rtc_q),
    .match_w(match_w), .expire(expire), .rtc_wrap(rtc_wrap)
);

// File: tb/dmt_timer_bench.sv
module dmt_timer_bench;
    localparam logic [7:0] R_CFG = 8'h00, R_MA = 8'h04, R_MB = 8'h08, R_CTL = 8'h0C;
    localparam logic [7:0] R_MSK = 8'h18, R_RAW = 8'h1C, R_MST = 8'h20, R_CLR = 8'h24;
    localparam logic [7:0] R_LA = 8'h28, R_LB = 8'h2C, R_XA = 8'h30, R_XB = 8'h34;
    localparam logic [7:0] R_CNT = 8'h48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sec_tick = 1'b0;
    logic        irq, trig;
    int          checks = 0;
    int          errors = 0;
    int          rtc_exp = 0;

    always #2.5 clk = ~clk;

    dmt_timer u_dmt_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sec_tick(sec_tick),
        .irq(irq), .trig(trig)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic strobe();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    // launch with load L; count cycles to first expiry and trigger pulses
    task automatic run_down(input int L, input bit one, input bit trg_on);
        int first, pulses, p;
        logic [31:0] v;
        wr(R_CTL, 32'h0); wr(R_CFG, 32'h0); wr(R_MA, {31'h0, one});
        wr(R_LA, L); wr(R_CLR, '1);
        wr(R_CTL, trg_on ? 32'h21 : 32'h01);
        first = 0; pulses = 0;
        for (int k = 1; k <= 24; k++) begin
            @(negedge clk);
            if (trig) pulses++;
            rd(R_RAW, v);
            if (first == 0 && v[0]) first = k;
        end
        p = (L == 0) ? 1 : L;
        chk($sformatf("R4 first expiry L=%0d", L), first, p);
        if (one) begin
            chk($sformatf("R6 single pulse L=%0d", L), pulses, trg_on ? 1 : 0);
            rd(R_CTL, v);
            chk($sformatf("R6 enable cleared L=%0d", L), v, trg_on ? 32'h20 : 32'h0);
        end else begin
            chk($sformatf("R5 R7 pulse count L=%0d", L), pulses, trg_on ? 24 / p : 0);
            wr(R_CTL, 32'h20);
            wr(R_CLR, '1);
            pulses = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (trig) pulses++;
            end
            rd(R_RAW, v);
            chk($sformatf("R8 no expiry after halt L=%0d", L), {v[31:1], 1'b0} | pulses, 32'h0);
            chk($sformatf("R8 raw quiet L=%0d", L), v, 32'h0);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] pat [4];
        logic [7:0]  sto [7];
        int          pulses;
        pat = '{32'hA5A5_5A5A, 32'h1234_5678, 32'hFFFF_FFFF, 32'h0};
        sto = '{R_CFG, R_MA, R_MB, 8'h38, 8'h3C, 8'h40, 8'h44};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        foreach (sto[i]) begin rd(sto[i], v); chk("R1 reset storage", v, 0); end
        rd(R_CTL, v); chk("R1 reset control", v, 0);
        rd(R_MSK, v); chk("R1 reset mask", v, 0);
        rd(R_RAW, v); chk("R1 reset raw", v, 0);
        rd(R_LA, v);  chk("R1 reset load", v, 0);
        rd(R_XA, v);  chk("R1 reset match", v, 0);
        chk("R1 reset irq", irq, 0);
        chk("R1 reset trig", trig, 0);

        // R2 plain storage and unmapped reads
        foreach (pat[j]) begin
            foreach (sto[i]) begin
                wr(sto[i], pat[j]);
                rd(sto[i], v);
                chk($sformatf("R2 storage ofs %h", sto[i]), v, pat[j]);
            end
        end
        wr(R_CFG, 0); wr(R_MA, 0);
        wr(R_CTL, 32'h120); rd(R_CTL, v); chk("R2 control", v, 32'h120);
        wr(R_CTL, 32'h0);
        rd(R_CLR, v); chk("R2 clear reads zero", v, 0);
        rd(8'h10, v); chk("R2 unmapped 10", v, 0);
        rd(8'h14, v); chk("R2 unmapped 14", v, 0);
        rd(8'h4C, v); chk("R2 unmapped 4C", v, 0);
        rd(8'h50, v); chk("R2 unmapped 50", v, 0);

        // R3 split halves for load and match
        for (int m = 0; m < 2; m++) begin
            logic [7:0] ra, rb;
            ra = (m == 0) ? R_LA : R_XA;
            rb = (m == 0) ? R_LB : R_XB;
            wr(R_CFG, 0); wr(ra, 32'hABCD_1234);
            rd(ra, v); chk("R3 combined write", v, 32'hABCD_1234);
            wr(R_CFG, 4); wr(ra, 32'h5555_7777);
            rd(ra, v); chk("R3 split low only", v, 32'h0000_7777);
            rd(rb, v); chk("R3 high kept", v, 32'h0000_ABCD);
            wr(rb, 32'hEEEE_9999);
            rd(rb, v); chk("R3 high via B", v, 32'h0000_9999);
            wr(R_CFG, 0);
            rd(ra, v); chk("R3 recombined", v, 32'h9999_7777);
            wr(ra, 0);
        end

        // R4 R5 R6 R7 R8 load sweep
        for (int L = 0; L <= 6; L++) begin
            run_down(L, 1'b1, 1'b1);
            run_down(L, 1'b0, 1'b1);
        end
        run_down(2, 1'b0, 1'b0);   // R7 trigger disabled
        run_down(3, 1'b1, 1'b0);

        // R13 config/mode writes while running do nothing until relaunch
        wr(R_CTL, 0); wr(R_CFG, 0); wr(R_MA, 0); wr(R_LA, 3); wr(R_CTL, 32'h21);
        wr(R_CFG, 1); wr(R_MA, 1);
        pulses = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk); sec_tick = (k % 2 == 0);
            if (trig) pulses++;
        end
        sec_tick = 1'b0;
        chk("R13 still periodic", pulses, 4);
        rd(R_CNT, v); chk("R13 strobes ignored", v, rtc_exp);
        wr(R_CTL, 0); wr(R_MA, 0);

        // R9 R10 seconds mode, match sweep
        for (int M = 0; M <= 3; M++) begin
            wr(R_CTL, 0); wr(R_CFG, 0); wr(R_XA, M); wr(R_CFG, 1); wr(R_CTL, 1);
            for (int n = 0; n < 6; n++) begin
                wr(R_CLR, '1);
                strobe();
                rtc_exp = (rtc_exp + 1 > M) ? 0 : rtc_exp + 1;
                rd(R_CNT, v); chk($sformatf("R9 R10 count M=%0d", M), v, rtc_exp);
                rd(R_RAW, v); chk($sformatf("R9 wrap flag M=%0d", M), v, (rtc_exp == 0) ? 32'h8 : 32'h0);
            end
        end
        // leave the count at 2 with match 3 and lower match below it
        wr(R_CTL, 0); wr(R_XA, 3); wr(R_CTL, 1);
        while (rtc_exp != 2) begin strobe(); rtc_exp = (rtc_exp + 1 > 3) ? 0 : rtc_exp + 1; end
        wr(R_CTL, 0); wr(R_XA, 1); wr(R_CTL, 1); wr(R_CLR, '1);
        strobe(); rtc_exp = 0;
        rd(R_CNT, v); chk("R9 above lowered match", v, 0);
        rd(R_RAW, v); chk("R9 wrap from above", v, 32'h8);

        // R11 mask and interrupt with raw bit 3 (not maskable)
        wr(R_MSK, '1); rd(R_MSK, v); chk("R11 mask keep", v, 32'h77);
        chk("R11 irq bit3 masked out", irq, 0);
        rd(R_MST, v); chk("R11 masked status bit3", v, 0);
        wr(R_CTL, 0);
        wr(R_CFG, 2); rd(R_CNT, v); chk("R10 counter zero off mode", v, 0);
        wr(R_CFG, 0);

        // R11 R12 expiry bit with mask
        run_down(1, 1'b1, 1'b1);
        @(negedge clk);
        chk("R11 irq high", irq, 1);
        rd(R_MST, v); chk("R11 masked status", v, 32'h1);
        wr(R_MSK, 32'h8);
        chk("R11 irq low unmasked bit", irq, 0);
        wr(R_MSK, 32'h1);
        wr(R_CLR, 32'h2); rd(R_RAW, v); chk("R12 other bits kept", v, 32'h1);
        wr(R_CLR, 32'h1); rd(R_RAW, v); chk("R12 bit cleared", v, 32'h0);
        chk("R12 irq after clear", irq, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule